// File: doc/BRIEF.md
# Base-Limit Memory Protection Checker

This block decides, for each memory access, whether the access may proceed and which memory attributes apply to it. Software in privileged mode programs up to sixteen protection regions through a simple register-write port. Each region covers one contiguous address range. The range runs from a base address to an inclusive limit address, and both ends are set in steps of 32 bytes. Each region also carries an access-permission code, an execute-never flag and a small index. That index selects one entry from a shared bank of eight attribute registers. No region needs a power-of-two size or alignment, and there are no subregions.

The access side is purely combinational. It takes the following inputs:
- the address;
- direction qualifiers: write or read, and instruction fetch;
- source qualifiers: privileged, debug, and exception-vector fetch;
- a flag that says the current execution priority is too high to take a memory-management fault.

From these it produces a permit or violation decision and the resolved attribute byte. A violation is reported as a memory-management fault. It is escalated to a hard fault when that fault is disabled or blocked by priority. On the clock edge of a violating access, a status register records the cause and a fault-address register records the data address.

Top module: `bl_prot_checker`

## Requirements
- R1: A region hits when the address is at or above the base with its low 5 bits cleared, and at or below the limit with its low 5 bits set. Region sizes need not be powers of two or aligned to their size.
- R2: Each of the 16 region slots is configured independently through the write port. Kind 0 is the base word: bits 31:5 base, bits 2:1 permission code, bit 0 execute-never. Kind 1 is the limit word: bits 31:5 limit, bits 3:1 attribute index, bit 0 enable. The target slot is selected by `cfg_idx`.
- R3: The permission codes are 00 = privileged read/write, 01 = read/write at any level, 10 = privileged read-only, 11 = read-only at any level. An unprivileged access to a privileged-only code violates. A write to a read-only code violates. An instruction fetch to an execute-never region violates.
- R4: A permitted access in a region outputs the attribute register selected by that region's index. Attribute registers are written with kind 2: `cfg_idx[2:0]` selects the register and data bits 7:0 give the value.
- R5: Kind 3 writes the control word: bit 0 enables protection, bit 1 enables the memory-management fault. With protection enabled, an access that hits no enabled region violates. With protection disabled, every non-system-fetch access is permitted. Whenever an access is not permitted by a region, the attribute output is 0x00.
- R6: An address that hits two or more enabled regions is a violation.
- R7: Debug accesses and exception-vector fetches are always permitted. So are non-fetch accesses to the private peripheral window 0xE000_0000–0xE00F_FFFF. All three bypass the regions.
- R8: An instruction fetch with address bits 31:29 = 111 always violates, whatever the region settings, unless it is a debug or vector access.
- R9: A violation raises `fault_mm` when the fault is enabled and `prio_block` is low; otherwise it raises `fault_hard`. At most one of the two is high, and neither is high when the access is permitted or `acc_valid` is low.
- R10: On the clock edge of a violating valid access, `fault_status` is overwritten with 0x01 for a fetch violation or 0x82 for a data violation (bit 7 = address valid). `fault_addr` captures the address on data violations only.
- R11: Reset clears all regions to disabled, clears protection and fault enables, clears the attribute registers, and sets `fault_status` and `fault_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Target kind: 0 base, 1 limit, 2 attribute, 3 control |
| cfg_idx | input | 4 | Region or attribute register index |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | Instruction fetch |
| acc_priv | input | 1 | Privileged access |
| acc_debug | input | 1 | Debugger access |
| acc_vector | input | 1 | Exception vector fetch |
| prio_block | input | 1 | Execution priority too high for memory-management fault |
| acc_permit | output | 1 | Access allowed |
| acc_attr | output | 8 | Resolved attribute byte |
| fault_mm | output | 1 | Memory-management fault |
| fault_hard | output | 1 | Escalated hard fault |
| fault_status | output | 8 | Last fault cause |
| fault_addr | output | 32 | Last data fault address |

## Verification
The bench probes the first and last byte of each region and the byte just outside each end. An off-by-one in the 5-bit granule extension would either let a neighbouring granule through or reject the limit byte. It targets an overlapped window, which a priority-encoded design would wrongly permit, and an execute-never fetch into the peripheral window, which a design that applies bypass before the system check would admit. It also confirms that a fetch fault leaves the captured address untouched, and that priority blocking or a disabled fault moves the report to the hard fault.

// File: rtl/bl_prot_pkg.sv
package bl_prot_pkg;

    parameter int ADDR_W     = 32;
    parameter int GRAN_BITS  = 5;
    parameter int ATTR_W     = 8;
    parameter int ATTR_IDX_W = 3;
    parameter int N_ATTR     = 1 << ATTR_IDX_W;
    parameter int PAGE_W     = ADDR_W - GRAN_BITS;
    parameter logic [ATTR_W-1:0] DEFAULT_ATTR = '0;

    typedef enum logic [1:0] {
        CFG_BASE  = 2'd0,
        CFG_LIMIT = 2'd1,
        CFG_ATTR  = 2'd2,
        CFG_CTRL  = 2'd3
    } cfg_kind_e;

    typedef enum logic [1:0] {
        AP_PRIV_RW = 2'b00,
        AP_ANY_RW  = 2'b01,
        AP_PRIV_RO = 2'b10,
        AP_ANY_RO  = 2'b11
    } perm_e;

    typedef struct packed {
        logic [PAGE_W-1:0]     base;
        logic [PAGE_W-1:0]     limit;
        perm_e                 perm;
        logic                  xn;
        logic [ATTR_IDX_W-1:0] aidx;
        logic                  en;
    } region_t;

    typedef struct packed {
        logic              permit;
        logic              viol;
        logic [ATTR_W-1:0] attr;
    } verdict_t;

    function automatic logic in_system_space(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: 3] == 3'b111;
    endfunction

    function automatic logic in_periph_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: 12] == 12'hE00;
    endfunction

endpackage

// File: rtl/bl_prot_cfg.sv
module bl_prot_cfg
    import bl_prot_pkg::*;
#(
    parameter int N_REG = 16,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_kind,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [ADDR_W-1:0]            cfg_wdata,
    output region_t [N_REG-1:0]          regions,
    output logic [N_ATTR-1:0][ATTR_W-1:0] attrs,
    output logic                         prot_en,
    output logic                         mm_en
);

    cfg_kind_e kind;
    assign kind = cfg_kind_e'(cfg_kind);

    for (genvar g = 0; g < N_REG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[g] <= '0;
            end else if (cfg_we && (32'(cfg_idx) == g)) begin
                if (kind == CFG_BASE) begin
                    regions[g].base <= cfg_wdata[ADDR_W-1:GRAN_BITS];
                    regions[g].perm <= perm_e'(cfg_wdata[2:1]);
                    regions[g].xn   <= cfg_wdata[0];
                end else if (kind == CFG_LIMIT) begin
                    regions[g].limit <= cfg_wdata[ADDR_W-1:GRAN_BITS];
                    regions[g].aidx  <= cfg_wdata[ATTR_IDX_W:1];
                    regions[g].en    <= cfg_wdata[0];
                end
            end
        end
    end

    for (genvar a = 0; a < N_ATTR; a++) begin : g_attr
        always_ff @(posedge clk) begin
            if (rst) begin
                attrs[a] <= '0;
            end else if (cfg_we && kind == CFG_ATTR &&
                         32'(cfg_idx[ATTR_IDX_W-1:0]) == a) begin
                attrs[a] <= cfg_wdata[ATTR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_en <= 1'b0;
            mm_en   <= 1'b0;
        end else if (cfg_we && kind == CFG_CTRL) begin
            prot_en <= cfg_wdata[0];
            mm_en   <= cfg_wdata[1];
        end
    end

    p_ctrl_write_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_kind == 2'd3) |=> (prot_en == $past(cfg_wdata[0])))
        else $error("control write not applied");

endmodule

// File: rtl/bl_prot_match.sv
module bl_prot_match
    import bl_prot_pkg::*;
#(
    parameter int N_REG = 16,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic [ADDR_W-1:0]    addr,
    input  region_t [N_REG-1:0]  regions,
    output logic [N_REG-1:0]     hit,
    output logic                 any_hit,
    output logic                 multi_hit,
    output logic [IDX_W-1:0]     sel
);

    logic [PAGE_W-1:0] page;
    assign page = addr[ADDR_W-1:GRAN_BITS];

    for (genvar g = 0; g < N_REG; g++) begin : g_cmp
        assign hit[g] = regions[g].en &&
                        (page >= regions[g].base) &&
                        (page <= regions[g].limit);
    end

    assign any_hit   = |hit;
    assign multi_hit = |(hit & (hit - 1'b1));

    always_comb begin
        sel = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (hit[i]) sel = IDX_W'(i);
        end
    end

endmodule

// File: rtl/bl_prot_decide.sv
module bl_prot_decide
    import bl_prot_pkg::*;
#(
    parameter int N_REG = 16,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          acc_valid,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic                          acc_write,
    input  logic                          acc_fetch,
    input  logic                          acc_priv,
    input  logic                          acc_debug,
    input  logic                          acc_vector,
    input  logic                          prot_en,
    input  region_t [N_REG-1:0]           regions,
    input  logic [N_ATTR-1:0][ATTR_W-1:0] attrs,
    input  logic                          any_hit,
    input  logic                          multi_hit,
    input  logic [IDX_W-1:0]              sel,
    output verdict_t                      verdict
);

    region_t r;
    logic priv_ok, write_ok, exec_ok;

    assign r        = regions[sel];
    assign priv_ok  = acc_priv || r.perm[0];
    assign write_ok = !acc_write || !r.perm[1];
    assign exec_ok  = !acc_fetch || !r.xn;

    always_comb begin
        verdict = '{permit: 1'b0, viol: 1'b0, attr: DEFAULT_ATTR};
        if (!acc_valid) begin
            verdict.permit = 1'b0;
        end else if (acc_debug || acc_vector) begin
            verdict.permit = 1'b1;
        end else if (acc_fetch && in_system_space(acc_addr)) begin
            verdict.viol = 1'b1;
        end else if (in_periph_window(acc_addr) || !prot_en) begin
            verdict.permit = 1'b1;
        end else if (!any_hit || multi_hit) begin
            verdict.viol = 1'b1;
        end else if (priv_ok && write_ok && exec_ok) begin
            verdict.permit = 1'b1;
            verdict.attr   = attrs[r.aidx];
        end else begin
            verdict.viol = 1'b1;
        end
    end

    p_sys_fetch_xn_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_fetch && acc_addr[31:29] == 3'b111 &&
         !acc_debug && !acc_vector) |-> !verdict.permit)
        else $error("fetch from system space permitted");

    p_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && prot_en && multi_hit && !acc_debug && !acc_vector &&
         !in_periph_window(acc_addr)) |-> !verdict.permit)
        else $error("overlapping hit permitted");

    p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_debug || acc_vector)) |-> verdict.permit)
        else $error("bypass access not permitted");

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(verdict.permit && verdict.viol))
        else $error("permit and violation together");

endmodule

// File: rtl/bl_prot_fault.sv
module bl_prot_fault
    import bl_prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              viol,
    input  logic              acc_fetch,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [7:0]        fault_status,
    output logic [ADDR_W-1:0] fault_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_status <= '0;
            fault_addr   <= '0;
        end else if (viol) begin
            if (acc_fetch) begin
                fault_status <= 8'h01;
            end else begin
                fault_status <= 8'h82;
                fault_addr   <= acc_addr;
            end
        end
    end

    p_data_addr_r10: assert property (@(posedge clk) disable iff (rst)
        (viol && !acc_fetch) |=> (fault_addr == $past(acc_addr)))
        else $error("data fault address not captured");

    p_fetch_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (viol && acc_fetch) |=> $stable(fault_addr))
        else $error("fetch fault changed fault address");

endmodule

// File: rtl/bl_prot_checker.sv
module bl_prot_checker
    import bl_prot_pkg::*;
#(
    parameter int N_REG = 16,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_priv,
    input  logic              acc_debug,
    input  logic              acc_vector,
    input  logic              prio_block,
    output logic              acc_permit,
    output logic [7:0]        acc_attr,
    output logic              fault_mm,
    output logic              fault_hard,
    output logic [7:0]        fault_status,
    output logic [31:0]       fault_addr
);

    region_t [N_REG-1:0]           regions;
    logic [N_ATTR-1:0][ATTR_W-1:0] attrs;
    logic                          prot_en, mm_en;
    logic [N_REG-1:0]              hit;
    logic                          any_hit, multi_hit;
    logic [IDX_W-1:0]              sel;
    verdict_t                      verdict;

    bl_prot_cfg #(.N_REG(N_REG)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .regions(regions),
        .attrs(attrs), .prot_en(prot_en), .mm_en(mm_en)
    );

    bl_prot_match #(.N_REG(N_REG)) u_match (
        .addr(acc_addr), .regions(regions), .hit(hit),
        .any_hit(any_hit), .multi_hit(multi_hit), .sel(sel)
    );

    bl_prot_decide #(.N_REG(N_REG)) u_decide (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_priv(acc_priv),
        .acc_debug(acc_debug), .acc_vector(acc_vector), .prot_en(prot_en),
        .regions(regions), .attrs(attrs), .any_hit(any_hit),
        .multi_hit(multi_hit), .sel(sel), .verdict(verdict)
    );

    bl_prot_fault u_fault (
        .clk(clk), .rst(rst), .viol(verdict.viol), .acc_fetch(acc_fetch),
        .acc_addr(acc_addr), .fault_status(fault_status),
        .fault_addr(fault_addr)
    );

    assign acc_permit = verdict.permit;
    assign acc_attr   = verdict.attr;
    assign fault_mm   = verdict.viol && mm_en && !prio_block;
    assign fault_hard = verdict.viol && (!mm_en || prio_block);

    p_one_fault_r9: assert property (@(posedge clk) disable iff (rst)
        !(fault_mm && fault_hard))
        else $error("both fault kinds raised");

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || acc_permit) |-> !(fault_mm || fault_hard))
        else $error("fault raised without violating access");

    p_blocked_escalates_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && prio_block) |-> !fault_mm)
        else $error("blocked priority took memory-management fault");

endmodule

// File: tb/bl_prot_checker_tb.sv
module bl_prot_checker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0, acc_fetch = 1'b0, acc_priv = 1'b0;
    logic        acc_debug = 1'b0, acc_vector = 1'b0, prio_block = 1'b0;
    logic        acc_permit, fault_mm, fault_hard;
    logic [7:0]  acc_attr, fault_status;
    logic [31:0] fault_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bl_prot_checker u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
        .acc_priv(acc_priv), .acc_debug(acc_debug), .acc_vector(acc_vector),
        .prio_block(prio_block), .acc_permit(acc_permit), .acc_attr(acc_attr),
        .fault_mm(fault_mm), .fault_hard(fault_hard),
        .fault_status(fault_status), .fault_addr(fault_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic wr, fe, pr, dbg, vec, blk;
        logic permit, mm, hard;
        logic [7:0] attr;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h11},
        '{32'h0000_3FFF, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h11},
        '{32'h0000_4000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h0003_BC00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h12},
        '{32'h0003_BBFF, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h0008_03FF, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h12},
        '{32'h0008_0400, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h0004_0000, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h0004_0000, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h0000_0100, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h11},
        '{32'h2000_0010, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h13},
        '{32'h2000_0010, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h2000_0020, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h6000_0040, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h17},
        '{32'h6000_00BF, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h6000_0080, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h4000_0100, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h14},
        '{32'h4000_0900, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'h4000_1000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h15},
        '{32'hE000_E100, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h00},
        '{32'hE000_E100, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'hE010_0000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 8'h00},
        '{32'hE000_0000, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h00},
        '{32'h0004_0000, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'h00},
        '{32'h0008_1000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0, 8'h00},
        '{32'h0004_0000, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1, 8'h00},
        '{32'h0000_0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0, 8'h11}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] k, input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_region(input int i, input logic [31:0] base, input logic [31:0] lim,
                              input logic [1:0] ap, input logic xn, input logic [2:0] ai);
        wr_cfg(2'd0, 4'(i), {base[31:5], 2'b00, ap, xn});
        wr_cfg(2'd1, 4'(i), {lim[31:5], 1'b0, ai, 1'b1});
    endtask

    task automatic drive(input logic [31:0] a, input logic w, input logic f, input logic p,
                         input logic d, input logic v, input logic b);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_fetch = f;
        acc_priv = p; acc_debug = d; acc_vector = v; prio_block = b;
        #5;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_fetch = 1'b0; acc_priv = 1'b0;
        acc_debug = 1'b0; acc_vector = 1'b0; prio_block = 1'b0;
        #5;
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state; R5 protection off permits with default attribute
        #5;
        chk("R11 status", 32'(fault_status), 32'h0);
        chk("R11 addr", fault_addr, 32'h0);
        drive(32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 permit off", 32'(acc_permit), 32'h1);
        chk("R5 default attr", 32'(acc_attr), 32'h0);
        idle();

        for (int a = 0; a < 8; a++) wr_cfg(2'd2, 4'(a), 32'(8'h10 + a));
        set_region(0,  32'h0000_0000, 32'h0000_3FE0, 2'b01, 1'b0, 3'd1);
        set_region(1,  32'h0003_BC00, 32'h0008_03E0, 2'b11, 1'b1, 3'd2);
        set_region(2,  32'h2000_0000, 32'h2000_0000, 2'b00, 1'b1, 3'd3);
        set_region(5,  32'h4000_0000, 32'h4000_0FE0, 2'b01, 1'b0, 3'd4);
        set_region(6,  32'h4000_0800, 32'h4000_1FE0, 2'b01, 1'b0, 3'd5);
        set_region(15, 32'h6000_0040, 32'h6000_00A0, 2'b10, 1'b0, 3'd7);
        wr_cfg(2'd3, 4'd0, 32'h3);

        // R1 R2 R3 R4 R5 R6 R7 R8 R9 vector table
        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].addr, VECS[v].wr, VECS[v].fe, VECS[v].pr,
                  VECS[v].dbg, VECS[v].vec, VECS[v].blk);
            chk($sformatf("R1-vec%0d permit", v), 32'(acc_permit), 32'(VECS[v].permit));
            chk($sformatf("R9 vec%0d mm", v), 32'(fault_mm), 32'(VECS[v].mm));
            chk($sformatf("R9 vec%0d hard", v), 32'(fault_hard), 32'(VECS[v].hard));
            chk($sformatf("R4 vec%0d attr", v), 32'(acc_attr), 32'(VECS[v].attr));
        end
        idle();

        // R10 data fault capture
        drive(32'h0000_4020, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle();
        chk("R10 data status", 32'(fault_status), 32'h82);
        chk("R10 data addr", fault_addr, 32'h0000_4020);

        // R10 fetch fault keeps address
        drive(32'h0004_0040, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        idle();
        chk("R10 fetch status", 32'(fault_status), 32'h01);
        chk("R10 fetch addr kept", fault_addr, 32'h0000_4020);

        // R9 invalid access raises nothing and leaves status
        @(negedge clk);
        acc_valid = 1'b0; acc_addr = 32'h0000_5000; acc_write = 1'b1;
        #5;
        chk("R9 idle mm", 32'(fault_mm), 32'h0);
        chk("R9 idle permit", 32'(acc_permit), 32'h0);
        idle();
        chk("R10 idle status", 32'(fault_status), 32'h01);

        // R9 fault disabled escalates
        wr_cfg(2'd3, 4'd0, 32'h1);
        drive(32'h0000_4000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 disabled hard", 32'(fault_hard), 32'h1);
        chk("R9 disabled mm", 32'(fault_mm), 32'h0);
        idle();

        // R2 disabling one slot removes its range
        wr_cfg(2'd1, 4'd15, {27'(32'h6000_00A0 >> 5), 5'b01110});
        drive(32'h6000_0040, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 disabled slot", 32'(acc_permit), 32'h0);
        idle();

        // R5 protection off permits unmapped, R8 system fetch still faults
        wr_cfg(2'd3, 4'd0, 32'h2);
        drive(32'h0000_4000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 off permit", 32'(acc_permit), 32'h1);
        chk("R5 off attr", 32'(acc_attr), 32'h0);
        drive(32'hF000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 off sys fetch", 32'(fault_mm), 32'h1);
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule